// File: doc/BRIEF.md
# Programmable Wait State Generator

This block stretches accesses to slow external memories and I/O devices. A bus master raises a one-cycle access request together with a region code; the block looks up that region's programmed wait field, marks the bus cycle as not ready for the required number of clock cycles, and then pulses a completion strobe. Six regions are served: program memory, data memory and four I/O windows. Each region has its own 3-bit field.

A single mode bit changes how every field is interpreted. With the bit clear, a field value N yields N stall cycles (0 to 7). With it set, N yields 2N+1 stall cycles (1 to 15). This doubles the range without widening the fields. The configuration is held in two 16-bit words that are reached through a small synchronous write port and a registered read port. Decoding addresses into regions is left to the surrounding logic.

Top module: `wait_state_gen`

## Requirements
- R1: Configuration word 0 (cfg_addr=0) holds the I/O fields IO0 at bits 2:0, IO1 at 5:3, IO2 at 8:6 and IO3 at 11:9, with the mode bit at bit 15. Word 1 (cfg_addr=1) holds the program-memory field at bits 2:0 and the data-memory field at bits 5:3. The region codes are 0 for program memory, 1 for data memory and 2 to 5 for IO0 to IO3.
- R2: With the mode bit at 0, an accepted request to a region whose field is N gives exactly N cycles with acc_busy high, followed by one cycle with acc_done high.
- R3: With the mode bit at 1, an accepted request to a region whose field is N gives exactly 2N+1 busy cycles, followed by one done cycle.
- R4: With zero wait cycles, acc_done is high in the cycle after the request and acc_busy never rises. acc_busy and acc_done are never high together.
- R5: After reset, every wait field is 7 and the mode bit is 0. Word 0 reads 0x0FFF and word 1 reads 0x003F.
- R6: Reserved bits (word 0 bits 14:12, word 1 bits 15:6) always read as zero, and writing ones to them has no effect.
- R7: The wait count is captured when a request is accepted. A configuration write made during an access does not alter that access.
- R8: A request made while acc_busy is high is ignored and starts no further access.
- R9: Region codes 6 and 7 complete with zero wait cycles in either mode.
- R10: cfg_rdata shows the word selected by cfg_addr one clock after cfg_addr is sampled, and it reflects writes made at earlier edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Write strobe for the configuration word |
| cfg_addr | input | 1 | Selects configuration word 0 or 1 |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Registered read data |
| acc_req | input | 1 | One-cycle access request |
| acc_region | input | 3 | Region code of the request |
| acc_busy | output | 1 | Not-ready: access is being stretched |
| acc_done | output | 1 | One-cycle access completion |

## Verification
The hardest case to reach from the ports is a configuration write that arrives while an access is already stalling. The stimulus starts a long access and rewrites the same region's field and the mode bit in the middle of the stall. It then checks that the stall length follows the old value and that the next access follows the new one. A second case issues a fresh request while busy is high and checks that no extra stall appears. The main sweep covers every region, every field value and both modes, and measures each stall against N or 2N+1.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
  localparam int REGION_W = 3;

  typedef enum logic [REGION_W-1:0] {
    RGN_PM  = 3'd0,
    RGN_DM  = 3'd1,
    RGN_IO0 = 3'd2,
    RGN_IO1 = 3'd3,
    RGN_IO2 = 3'd4,
    RGN_IO3 = 3'd5
  } region_e;

  localparam int FLD_PM  = 0;
  localparam int FLD_DM  = 1;
  localparam int FLD_IO0 = 2;
endpackage

// File: rtl/wsg_regs.sv
module wsg_regs #(
  parameter int REG_W   = 16,
  parameter int FIELD_W = 3,
  parameter int NUM_IO  = 4
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               wr_en,
  input  logic                               addr,
  input  logic [REG_W-1:0]                   wdata,
  output logic [REG_W-1:0]                   rdata,
  output logic [(NUM_IO+2)*FIELD_W-1:0]      fields_o,
  output logic                               mode_o
);
  import wsg_pkg::*;
  localparam int NUM_FLD  = NUM_IO + 2;
  localparam int MODE_BIT = REG_W - 1;
  localparam int IO_TOP   = NUM_IO * FIELD_W;

  logic [FIELD_W-1:0] fld [NUM_FLD];
  logic               mode_q;
  logic [REG_W-1:0]   word_io, word_mem;

  always_comb begin
    word_io = '0;
    for (int i = 0; i < NUM_IO; i++)
      word_io[i*FIELD_W +: FIELD_W] = fld[FLD_IO0+i];
    word_io[MODE_BIT] = mode_q;
    word_mem = '0;
    word_mem[0 +: FIELD_W]       = fld[FLD_PM];
    word_mem[FIELD_W +: FIELD_W] = fld[FLD_DM];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_FLD; k++) fld[k] <= '1;
      mode_q <= 1'b0;
      rdata  <= '0;
    end else begin
      rdata <= addr ? word_mem : word_io;
      if (wr_en) begin
        if (!addr) begin
          for (int i = 0; i < NUM_IO; i++)
            fld[FLD_IO0+i] <= wdata[i*FIELD_W +: FIELD_W];
          mode_q <= wdata[MODE_BIT];
        end else begin
          fld[FLD_PM] <= wdata[0 +: FIELD_W];
          fld[FLD_DM] <= wdata[FIELD_W +: FIELD_W];
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_FLD; g++) begin : g_flat
    assign fields_o[g*FIELD_W +: FIELD_W] = fld[g];
  end
  assign mode_o = mode_q;

  assert_rsvd_zero_R6: assert property (@(posedge clk) disable iff (rst)
    rdata[MODE_BIT-1:IO_TOP] == '0);

  assert_mode_write_R1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !addr) |=> (mode_o == $past(wdata[MODE_BIT])));
endmodule

// File: rtl/wsg_calc.sv
module wsg_calc #(
  parameter int FIELD_W  = 3,
  parameter int NUM_IO   = 4,
  parameter int REGION_W = 3
) (
  input  logic [(NUM_IO+2)*FIELD_W-1:0] fields_i,
  input  logic                          mode_i,
  input  logic [REGION_W-1:0]           region_i,
  output logic [FIELD_W:0]              wait_o
);
  localparam int NUM_FLD = NUM_IO + 2;

  logic [FIELD_W-1:0] sel;
  logic               hit;

  always_comb begin
    sel = '0;
    hit = 1'b0;
    for (int k = 0; k < NUM_FLD; k++) begin
      if (region_i == REGION_W'(k)) begin
        sel = fields_i[k*FIELD_W +: FIELD_W];
        hit = 1'b1;
      end
    end
    if (!hit)        wait_o = '0;
    else if (mode_i) wait_o = {sel, 1'b1};
    else             wait_o = {1'b0, sel};
  end
endmodule

// File: rtl/wsg_seq.sv
module wsg_seq #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [CNT_W-1:0] wait_i,
  output logic             busy,
  output logic             done
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      left <= '0;
    end else if (busy) begin
      if (left == ONE) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
      left <= left - ONE;
    end else begin
      done <= 1'b0;
      if (req) begin
        if (wait_i == '0) begin
          done <= 1'b1;
        end else begin
          busy <= 1'b1;
          left <= wait_i;
        end
      end
    end
  end

  assert_busy_done_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  assert_stall_ends_done_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  assert_busy_ignores_req_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && left > ONE) |=> (busy && left == $past(left) - ONE));

  assert_zero_wait_R4: assert property (@(posedge clk) disable iff (rst)
    (!busy && req && wait_i == '0) |=> (done && !busy));
endmodule

// File: rtl/wait_state_gen.sv
module wait_state_gen #(
  parameter int REG_W    = 16,
  parameter int FIELD_W  = 3,
  parameter int NUM_IO   = 4,
  parameter int REGION_W = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_wr_en,
  input  logic                cfg_addr,
  input  logic [REG_W-1:0]    cfg_wdata,
  output logic [REG_W-1:0]    cfg_rdata,
  input  logic                acc_req,
  input  logic [REGION_W-1:0] acc_region,
  output logic                acc_busy,
  output logic                acc_done
);
  localparam int NUM_FLD  = NUM_IO + 2;
  localparam int CNT_W    = FIELD_W + 1;
  localparam int FLD_MAX  = (1 << FIELD_W) - 1;

  logic [NUM_FLD*FIELD_W-1:0] fields;
  logic                       mode;
  logic [CNT_W-1:0]           wait_cyc;

  wsg_regs #(.REG_W(REG_W), .FIELD_W(FIELD_W), .NUM_IO(NUM_IO)) regs_i (
    .clk(clk), .rst(rst), .wr_en(cfg_wr_en), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .fields_o(fields), .mode_o(mode)
  );

  wsg_calc #(.FIELD_W(FIELD_W), .NUM_IO(NUM_IO), .REGION_W(REGION_W)) calc_i (
    .fields_i(fields), .mode_i(mode), .region_i(acc_region), .wait_o(wait_cyc)
  );

  wsg_seq #(.CNT_W(CNT_W)) seq_i (
    .clk(clk), .rst(rst), .req(acc_req), .wait_i(wait_cyc),
    .busy(acc_busy), .done(acc_done)
  );

  assert_mode0_range_R2: assert property (@(posedge clk) disable iff (rst)
    !mode |-> (wait_cyc <= CNT_W'(FLD_MAX)));

  assert_mode1_odd_R3: assert property (@(posedge clk) disable iff (rst)
    (mode && acc_region < REGION_W'(NUM_FLD)) |-> wait_cyc[0]);

  assert_accept_R7: assert property (@(posedge clk) disable iff (rst)
    (acc_req && !acc_busy && wait_cyc != '0) |=> acc_busy);
endmodule

// File: tb/wait_state_gen_tb_top.sv
`timescale 1ns/1ps
module wait_state_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr_en = 1'b0;
  logic        cfg_addr = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        acc_req = 1'b0;
  logic [2:0]  acc_region = '0;
  logic        acc_busy, acc_done;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  wait_state_gen dut_i (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_req(acc_req),
    .acc_region(acc_region), .acc_busy(acc_busy), .acc_done(acc_done)
  );

  // behavioural reference model
  int          m_f [6];
  bit          m_mode;
  int          m_left;
  bit          m_busy, m_done;
  logic [15:0] m_rdata;

  function automatic logic [15:0] m_word(input bit a);
    logic [15:0] w = '0;
    if (!a) begin
      for (int i = 0; i < 4; i++) w[i*3 +: 3] = 3'(m_f[2+i]);
      w[15] = m_mode;
    end else begin
      w[2:0] = 3'(m_f[0]);
      w[5:3] = 3'(m_f[1]);
    end
    return w;
  endfunction

  function automatic int m_wait(input int rg);
    if (rg > 5) return 0;
    return m_mode ? 2*m_f[rg] + 1 : m_f[rg];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 6; i++) m_f[i] <= 7;
      m_mode <= 0; m_busy <= 0; m_done <= 0; m_left <= 0; m_rdata <= '0;
    end else begin
      m_rdata <= m_word(cfg_addr);
      if (cfg_wr_en) begin
        if (!cfg_addr) begin
          for (int i = 0; i < 4; i++) m_f[2+i] <= int'(cfg_wdata[i*3 +: 3]);
          m_mode <= cfg_wdata[15];
        end else begin
          m_f[0] <= int'(cfg_wdata[2:0]);
          m_f[1] <= int'(cfg_wdata[5:3]);
        end
      end
      if (m_busy) begin
        m_busy <= (m_left != 1);
        m_done <= (m_left == 1);
        m_left <= m_left - 1;
      end else if (acc_req) begin
        m_busy <= (m_wait(int'(acc_region)) > 0);
        m_done <= (m_wait(int'(acc_region)) == 0);
        m_left <= m_wait(int'(acc_region));
      end else begin
        m_done <= 0;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      tests++;
      if (acc_busy !== m_busy || acc_done !== m_done) begin
        fails++;
        $display("FAIL R4 per-clock handshake: busy=%0b done=%0b expected busy=%0b done=%0b",
                 acc_busy, acc_done, m_busy, m_done);
      end
      tests++;
      if (cfg_rdata !== m_rdata) begin
        fails++;
        $display("FAIL R10 per-clock rdata: got %h expected %h", cfg_rdata, m_rdata);
      end
    end
  end

  task automatic check(input string req, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input bit a, input logic [15:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic rd(input bit a, output logic [15:0] d);
    @(negedge clk);
    cfg_addr = a;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  // issue one request and measure the stall; returns busy cycles, -1 if no done
  task automatic access(input logic [2:0] rg, output int stall);
    @(negedge clk);
    acc_req = 1'b1; acc_region = rg;
    @(negedge clk);
    acc_req = 1'b0;
    stall = 0;
    for (int c = 0; c < 40; c++) begin
      if (acc_done) return;
      if (acc_busy) stall++;
      @(negedge clk);
    end
    stall = -1;
  endtask

  initial begin
    logic [15:0] d;
    int st;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R5 reset state
    rd(1'b0, d); check("R5 word0 reset", int'(d), 16'h0FFF);
    rd(1'b1, d); check("R5 word1 reset", int'(d), 16'h003F);
    access(3'd0, st); check("R5 PM stall after reset", st, 7);

    // R6 reserved bits
    wr(1'b0, 16'hFFFF); rd(1'b0, d); check("R6 word0 reserved", int'(d), 16'h8FFF);
    wr(1'b1, 16'hFFFF); rd(1'b1, d); check("R6 word1 reserved", int'(d), 16'h003F);

    // R1 field placement, R10 read-back
    wr(1'b0, 16'h0000 | (16'd1) | (16'd2 << 3) | (16'd3 << 6) | (16'd4 << 9));
    wr(1'b1, 16'd5 | (16'd6 << 3));
    rd(1'b0, d); check("R10 word0 readback", int'(d), 16'h08D1);
    rd(1'b1, d); check("R10 word1 readback", int'(d), 16'h0035);
    for (int r = 0; r < 6; r++) begin
      access(3'(r), st);
      check("R1 region field", st, (r == 0) ? 5 : (r == 1) ? 6 : r - 1);
    end

    // R2/R3/R4 sweep over modes, values, regions
    for (int md = 0; md < 2; md++) begin
      for (int n = 0; n < 8; n++) begin
        wr(1'b0, 16'(n | (n << 3) | (n << 6) | (n << 9) | (md << 15)));
        wr(1'b1, 16'(n | (n << 3)));
        for (int r = 0; r < 6; r++) begin
          access(3'(r), st);
          if (md == 0) check(n == 0 ? "R4 zero wait" : "R2 N stall", st, n);
          else         check("R3 2N+1 stall", st, 2*n + 1);
        end
      end
      // R9 unused region codes
      access(3'd6, st); check("R9 region 6", st, 0);
      access(3'd7, st); check("R9 region 7", st, 0);
    end

    // R7 write during an access
    wr(1'b0, 16'h0000);
    wr(1'b1, 16'h0007);
    @(negedge clk); acc_req = 1'b1; acc_region = 3'd0;
    @(negedge clk); acc_req = 1'b0; cfg_wr_en = 1'b1; cfg_addr = 1'b1; cfg_wdata = 16'h0000;
    @(negedge clk); cfg_wr_en = 1'b1; cfg_addr = 1'b0; cfg_wdata = 16'h8000;
    @(negedge clk); cfg_wr_en = 1'b0;
    st = 0;
    for (int c = 0; c < 40 && !acc_done; c++) begin
      if (acc_busy) st++;
      @(negedge clk);
    end
    check("R7 stall keeps captured count", st + 2, 7);
    access(3'd0, st); check("R7 next access uses new field", st, 1);

    // R8 request during busy
    wr(1'b0, 16'h0000);
    wr(1'b1, 16'h0004);
    @(negedge clk); acc_req = 1'b1; acc_region = 3'd0;
    @(negedge clk); acc_region = 3'd0;
    @(negedge clk); acc_req = 1'b0;
    for (int c = 0; c < 40 && !acc_done; c++) @(negedge clk);
    @(negedge clk);
    check("R8 no access after done", int'(acc_busy) + int'(acc_done), 0);

    finished = 1;
  end

  initial begin
    for (int c = 0; c < 200000 && !finished; c++) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule